// File: doc/BRIEF.md
# Configuration Image Checksum Checker

This block checks the integrity of a configuration image as it streams past. The image arrives one 16-bit word per accepted cycle on a valid-qualified input. A separate marker flags the final word. Every word ahead of the marker is summed into a 32-bit running total. The flagged word is not summed: it is taken as the checksum stored with the image.

When the flagged word is accepted, the block compares the low half of the running total with the stored checksum. One cycle later it raises a one-cycle result strobe together with a pass bit. A total of exactly zero is rejected even when the low half matches. This catches blank or erased images, whose words and checksum all read as zero. The running total clears when a result is produced, so a new image may start in the very next cycle.

The word width and the accumulator width are parameters. The defaults are 16 and 32 bits.

Top module: `cfg_sum_checker`

## Requirements
- R1: Each accepted word that does not carry the last marker is added into a 32-bit running total, modulo 2^32.
- R2: The word that carries the last marker is the stored checksum and is never added to the total.
- R3: A result passes only when bits 15..0 of the total equal the stored checksum. Bits 31..16 of the total play no part in this comparison.
- R4: A total of exactly zero gives a failing result, even when the stored checksum is also zero.
- R5: `res_valid` is high for exactly one cycle, the cycle after a last-marked word is accepted, and is low in every other cycle. `res_pass` is low whenever `res_valid` is low.
- R6: In a cycle where `in_valid` is low, `in_word` and `in_last` are ignored. Such a cycle adds nothing to the total and produces no result.
- R7: The total is cleared when a last-marked word is accepted. A word accepted in the following cycle begins a fresh image.
- R8: An image made of a single last-marked word has no data words and reports failure.
- R9: Reset clears the total and drives `res_valid` and `res_pass` low. A partial image in progress at reset has no effect on the next image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies `in_word` and `in_last` in this cycle |
| in_word | input | WORD_W | Image word; this is the stored checksum when `in_last` is high |
| in_last | input | 1 | Marks the final word of the image |
| res_valid | output | 1 | One-cycle strobe carrying the verdict for the image just ended |
| res_pass | output | 1 | High when the image checked good; valid only with `res_valid` |

## Verification
The bench targets the cases a careless checker gets wrong, and each has a visible symptom.

- An all-zero image with a zero checksum: a checker that only compares would pass it.
- An image whose checksum equals its only data word: a checker that also sums the last word would fail it.
- A total that carries above bit 15 while its low half matches: a checker that compares all bits would fail it.
- A single-word image: this must fail.

Back-to-back images with no idle cycle expose a total that is not cleared in time, because the next verdict then comes out wrong. Idle cycles that carry a random word and a high last marker expose a design that does not gate on `in_valid`, because a stray result strobe then appears. A reset in the middle of an image shows whether leftover sum leaks into the following image.

// File: rtl/cfg_sum_pkg.sv
`timescale 1ns/1ps
package cfg_sum_pkg;
  localparam int unsigned DEF_WORD_W = 16;
  localparam int unsigned DEF_ACC_W  = 32;

  typedef struct packed {
    logic valid;
    logic pass;
  } csum_result_t;
endpackage

// File: rtl/csum_take_decode.sv
`timescale 1ns/1ps
// Splits an accepted input beat into a data-word event or a checksum event.
module csum_take_decode (
  input  logic in_valid,
  input  logic in_last,
  output logic take_data,
  output logic take_last
);
  assign take_data = in_valid & ~in_last;
  assign take_last = in_valid &  in_last;
endmodule

// File: rtl/csum_accum.sv
`timescale 1ns/1ps
// Running total of data words; wraps modulo 2^ACC_W.
module csum_accum #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_data,
  input  logic              clear,
  input  logic [WORD_W-1:0] word,
  output logic [ACC_W-1:0]  acc_q
);
  localparam int unsigned PAD = ACC_W - WORD_W;

  logic [ACC_W-1:0] word_wide;

  generate
    if (PAD > 0) begin : g_pad
      assign word_wide = {{PAD{1'b0}}, word};
    end else begin : g_nopad
      assign word_wide = word[ACC_W-1:0];
    end
  endgenerate

  function automatic logic [ACC_W-1:0] acc_step(input logic [ACC_W-1:0] a,
                                                input logic [ACC_W-1:0] b);
    return a + b;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clear) begin
      acc_q <= '0;
    end else if (take_data) begin
      acc_q <= acc_step(acc_q, word_wide);
    end
  end
endmodule

// File: rtl/csum_judge.sv
`timescale 1ns/1ps
// Forms the verdict from the total and the stored checksum and registers it.
module csum_judge
  import cfg_sum_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_last,
  input  logic [ACC_W-1:0]  acc,
  input  logic [WORD_W-1:0] stored,
  output csum_result_t      res_q
);
  logic sum_is_zero;
  logic low_match;

  function automatic logic judge(input logic [ACC_W-1:0]  total,
                                 input logic [WORD_W-1:0] csum);
    return (|total) && (total[WORD_W-1:0] == csum);
  endfunction

  assign sum_is_zero = ~(|acc);
  assign low_match   = (acc[WORD_W-1:0] == stored);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q <= '0;
    end else begin
      res_q.valid <= take_last;
      res_q.pass  <= take_last & judge(acc, stored);
    end
  end
endmodule

// File: rtl/cfg_sum_checker.sv
`timescale 1ns/1ps
// Top: streaming checksum checker for a configuration image.
module cfg_sum_checker
  import cfg_sum_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned ACC_W  = DEF_ACC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_last,
  output logic              res_valid,
  output logic              res_pass
);
  logic             take_data;
  logic             take_last;
  logic [ACC_W-1:0] acc_q;
  csum_result_t     res_q;

  csum_take_decode i_decode (
    .in_valid (in_valid),
    .in_last  (in_last),
    .take_data(take_data),
    .take_last(take_last)
  );

  csum_accum #(.WORD_W(WORD_W), .ACC_W(ACC_W)) i_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_data(take_data),
    .clear    (take_last),
    .word     (in_word),
    .acc_q    (acc_q)
  );

  csum_judge #(.WORD_W(WORD_W), .ACC_W(ACC_W)) i_judge (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_last(take_last),
    .acc      (acc_q),
    .stored   (in_word),
    .res_q    (res_q)
  );

  assign res_valid = res_q.valid;
  assign res_pass  = res_q.pass;
endmodule

// File: rtl/cfg_sum_checker_sva.sv
`timescale 1ns/1ps
module cfg_sum_checker_sva #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ACC_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_word,
  input logic              in_last,
  input logic              res_valid,
  input logic              res_pass,
  input logic [ACC_W-1:0]  acc_q
);
  p_accum_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_last) |=> acc_q == $past(acc_q) + ACC_W'($past(in_word)));

  p_pass_needs_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && acc_q[WORD_W-1:0] != in_word) |=> !res_pass);

  p_zero_sum_fails_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && acc_q == '0) |=> !res_pass);

  p_result_follows_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> res_valid);

  p_no_stray_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_last) |=> !res_valid);

  p_pass_qualified_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_pass);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(acc_q));

  p_clear_after_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> acc_q == '0);
endmodule

bind cfg_sum_checker cfg_sum_checker_sva #(.WORD_W(WORD_W), .ACC_W(ACC_W)) i_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_word  (in_word),
  .in_last  (in_last),
  .res_valid(res_valid),
  .res_pass (res_pass),
  .acc_q    (acc_q)
);

// File: tb/test_cfg_sum_checker.sv
`timescale 1ns/1ps
module test_cfg_sum_checker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_word;
  logic        in_last;
  logic        res_valid;
  logic        res_pass;

  always #2 clk = ~clk;

  cfg_sum_checker i_cfg_sum_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_last(in_last), .res_valid(res_valid), .res_pass(res_pass)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;

  logic [15:0] s_word  [0:1023];
  bit          s_valid [0:1023];
  bit          s_last  [0:1023];
  bit          s_exp   [0:1023];
  string       s_tag   [0:1023];
  int          s_n = 0;
  logic [31:0] run_sum = '0;

  function automatic bit exp_pass(input logic [31:0] sum, input logic [15:0] csum);
    if (sum == 32'd0) return 1'b0;
    return sum[15:0] == csum;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input bit v, input logic [15:0] w, input bit l,
                      input bit e, input string tag);
    s_valid[s_n] = v; s_word[s_n] = w; s_last[s_n] = l;
    s_exp[s_n] = e; s_tag[s_n] = tag;
    s_n++;
  endtask

  task automatic img_data(input logic [15:0] w);
    run_sum = run_sum + {16'd0, w};
    push(1'b1, w, 1'b0, 1'b0, "R1");
  endtask

  task automatic img_end(input logic [15:0] csum, input string tag);
    push(1'b1, csum, 1'b1, exp_pass(run_sum, csum), tag);
    run_sum = '0;
  endtask

  // Idle beat: valid low, random word, last high half the time (R6).
  task automatic img_idle();
    push(1'b0, 16'($urandom), 1'($urandom), 1'b0, "R6");
  endtask

  task automatic check_after(input int k);
    if (s_valid[k] && s_last[k]) begin
      chk(res_valid == 1'b1, "R5", "result strobe after last", int'(res_valid), 1);
      chk(res_pass == s_exp[k], s_tag[k], "verdict", int'(res_pass), int'(s_exp[k]));
    end else begin
      chk(res_valid == 1'b0, s_valid[k] ? "R5" : "R6", "no strobe", int'(res_valid), 0);
      chk(res_pass == 1'b0, "R5", "pass low without strobe", int'(res_pass), 0);
    end
  endtask

  task automatic run_stream();
    for (int j = 0; j < s_n; j++) begin
      @(negedge clk);
      if (j > 0) check_after(j - 1);
      in_valid = s_valid[j]; in_word = s_word[j]; in_last = s_last[j];
    end
    @(negedge clk);
    if (s_n > 0) check_after(s_n - 1);
    in_valid = 1'b0; in_last = 1'b0;
    @(negedge clk);
    chk(res_valid == 1'b0, "R5", "strobe lasts one cycle", int'(res_valid), 0);
    s_n = 0;
  endtask

  initial begin
    int seed_init;
    seed_init = $urandom(32'h5EED);
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; in_last = 1'b0;
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R9", "reset res_valid", int'(res_valid), 0);
    chk(res_pass == 1'b0, "R9", "reset res_pass", int'(res_pass), 0);
    rst_n = 1'b1;

    // R3: plain match and mismatch
    img_data(16'd1); img_data(16'd2); img_data(16'd3); img_end(16'd6, "R3");
    img_data(16'd1); img_data(16'd2); img_data(16'd3); img_end(16'd7, "R3");
    // R2: checksum equal to the only data word passes only if last is not summed
    img_data(16'h1234); img_end(16'h1234, "R2");
    // R3: carry above bit 15 with a matching low half passes
    img_data(16'hFFFF); img_data(16'h0002); img_end(16'h0001, "R3");
    // R4: all-zero image with zero checksum fails
    img_data(16'h0000); img_data(16'h0000); img_end(16'h0000, "R4");
    // R8: single-word images fail
    img_end(16'h0000, "R8");
    img_end(16'h0005, "R8");
    // R7: back-to-back images, no idle between them
    img_data(16'h00AA); img_end(16'h00AA, "R7");
    img_data(16'h0001); img_end(16'h0001, "R7");
    // R6: idle beats with garbage inside an image
    img_data(16'h0100); img_idle(); img_idle(); img_data(16'h0020); img_idle();
    img_end(16'h0120, "R6");
    run_stream();

    // R9: reset in the middle of an image
    img_data(16'h0300); img_data(16'h0400);
    run_stream();
    run_sum = '0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(res_valid == 1'b0, "R9", "mid-image reset res_valid", int'(res_valid), 0);
    rst_n = 1'b1;
    img_data(16'd4); img_data(16'd5); img_end(16'd9, "R9");
    run_stream();

    // Random images (R1, R3)
    for (int m = 0; m < 60; m++) begin
      int nw;
      nw = int'($urandom % 12);
      for (int w = 0; w < nw; w++) begin
        if ($urandom % 4 == 0) img_idle();
        img_data(($urandom % 5 == 0) ? 16'h0000 : 16'($urandom));
      end
      if ($urandom % 2 == 0) img_end(run_sum[15:0], "R1");
      else                   img_end(16'($urandom), "R3");
    end
    run_stream();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("[TB] FAIL watchdog R5 actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule